// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block receives stereo audio from a three-wire serial port. The port has a bit clock, a left/right frame clock and one data line. The block returns each channel pair as two parallel words of up to 24 bits, with a one-cycle valid strobe. All three port wires arrive asynchronously. They are synchronized into a single system clock, and the bit clock is oversampled there, so the block works only as a slave: it never drives the bit clock or the frame clock.

A 3-bit mode input picks the framing. The choices are left-justified, I2S, and four right-justified word lengths (24, 20, 18 and 16 bits). Words shorter than the output width are placed with their MSB at the top of the output word, and the unused low bits read zero. A pair is reported only once a full left half-frame and then a full right half-frame have been received.

The system clock must be fast enough that every high phase and every low phase of the bit clock lasts at least three system clock cycles. The mode code must stay constant while a frame is in progress.

Top module: `aud_serial_rx`

## Requirements
- R1: The bit clock, frame clock and data inputs pass through a synchronizer into the system clock. The data bit and the frame clock level are both taken at each rising bit clock edge.
- R2: Mode codes are: 000 left-justified, 001 I2S, 100 right-justified 24-bit, 101 right-justified 20-bit, 110 right-justified 18-bit, 111 right-justified 16-bit. The unused codes 010 and 011 behave exactly like 000.
- R3: Left-justified mode:
  - The MSB is the bit sampled at the first rising bit clock edge that sees the new frame clock level.
  - A high frame clock marks the left channel.
  - The first 24 bits of a half-frame are kept, and any later bits in that half-frame are ignored.
- R4: I2S mode:
  - The MSB is the bit sampled at the second rising edge after the frame clock changes.
  - The bit at the first rising edge is not part of the word.
  - A low frame clock marks the left channel.
- R5: Right-justified modes:
  - The LSB is the last bit sampled before the next frame clock change, and only the final N bits of the half-frame are kept.
  - Earlier bits are ignored.
  - A high frame clock marks the left channel.
- R6: Words shorter than 24 bits are MSB-aligned in the output, with the unused LSBs set to zero. This covers right-justified 20, 18 and 16 bits, and a left-justified half-frame shorter than 24 bit clocks.
- R7: valid_o pulses for exactly one system clock when a right half-frame completes after a completed left half-frame. left_o and right_o change only in that cycle and hold their values otherwise.
- R8: After reset, the first frame clock change only establishes alignment. The partial half-frame before it never produces output, and a right half-frame that has no preceding left half-frame is dropped.
- R9: An active-low asynchronous reset clears left_o, right_o and valid_o to zero. The reset is released synchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock (asynchronous) |
| lrclk_i | input | 1 | Left/right frame clock (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first |
| mode_i | input | 3 | Framing select code |
| valid_o | output | 1 | One-cycle strobe when a channel pair is complete |
| left_o | output | DATA_W | Left channel word, MSB-aligned |
| right_o | output | DATA_W | Right channel word, MSB-aligned |

## Verification
The bench covers the following corner cases:
- **Slots padded with ones.** Every slot is 32 bit clocks long, and the bits outside the word are filled with ones. A receiver that read the wrong slot positions would therefore set stray low bits or shift the whole word. This catches an I2S capture that is off by one bit, and a right-justified window of the wrong width.
- **Short left-justified half-frames and narrow right-justified modes.** Half-frames shorter than the word, and the narrow right-justified modes, check that the unused LSBs read zero. A design that kept stale bits or shifted right instead of left would fail here.
- **Lead-in after every reset.** Each reset is followed by a partial lead-in half-frame. A receiver that did not wait for alignment, or that paired a lone right channel, would emit an unexpected strobe.
- **Unused mode code.** An unused mode code is run to show that it falls back to left-justified framing.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_I2S = 2'd1,
    FMT_RJ  = 2'd2
  } fmt_e;

  localparam logic [2:0] MODE_LJ   = 3'b000;
  localparam logic [2:0] MODE_I2S  = 3'b001;
  localparam logic [2:0] MODE_RJ24 = 3'b100;
  localparam logic [2:0] MODE_RJ20 = 3'b101;
  localparam logic [2:0] MODE_RJ18 = 3'b110;
  localparam logic [2:0] MODE_RJ16 = 3'b111;

  // Framing family of a mode code; unused codes fall back to left-justified (R2)
  function automatic fmt_e fmt_of(input logic [2:0] m);
    if (m == MODE_I2S) return FMT_I2S;
    else if (m[2])     return FMT_RJ;
    else               return FMT_LJ;
  endfunction

  // Word length kept in the right-justified modes
  function automatic int rj_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return 24;
      2'd1:    return 20;
      2'd2:    return 18;
      default: return 16;
    endcase
  endfunction

  // Frame clock level that marks the left channel
  function automatic logic left_level(input fmt_e f);
    return (f != FMT_I2S);
  endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/aud_rx_slot.sv
module aud_rx_slot
  import aud_rx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int POS_W  = $clog2(DATA_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              sd_i,
  input  logic              lr_i,
  input  logic [2:0]        mode_i,
  output logic              done_o,
  output logic              left_o,
  output logic [DATA_W-1:0] word_o
);

  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic              primed_q, primed_n;
  logic              armed_q,  armed_n;
  logic              lr_q,     lr_n;
  logic [POS_W-1:0]  pos_q,    pos_n;
  logic [DATA_W-1:0] cap_q,    cap_n;
  logic [DATA_W-1:0] shr_q,    shr_n;

  fmt_e fmt;
  logic frame_edge;
  int   slot_idx;

  function automatic logic [DATA_W-1:0] rj_align(input logic [DATA_W-1:0] s, input int n);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int b = 0; b < DATA_W; b++) begin
      if (b >= DATA_W - n) r[b] = s[b-(DATA_W-n)];
    end
    return r;
  endfunction

  assign fmt        = fmt_of(mode_i);
  assign frame_edge = bit_en_i & primed_q & (lr_i != lr_q);
  assign slot_idx   = (fmt == FMT_I2S) ? int'(pos_q) - 1 : int'(pos_q);

  always_comb begin
    primed_n = primed_q;
    armed_n  = armed_q;
    lr_n     = lr_q;
    pos_n    = pos_q;
    cap_n    = cap_q;
    shr_n    = shr_q;
    if (bit_en_i) begin
      primed_n = 1'b1;
      lr_n     = lr_i;
      if (frame_edge) begin
        // first bit of a new half-frame is position 0
        armed_n = 1'b1;
        pos_n   = {{(POS_W-1){1'b0}}, 1'b1};
        shr_n   = {{(DATA_W-1){1'b0}}, sd_i};
        cap_n   = '0;
        if (fmt == FMT_LJ) cap_n[DATA_W-1] = sd_i;
      end else begin
        shr_n = {shr_q[DATA_W-2:0], sd_i};
        if (pos_q != POS_MAX) pos_n = pos_q + 1'b1;
        if (fmt != FMT_RJ) begin
          for (int b = 0; b < DATA_W; b++) begin
            if (slot_idx == DATA_W - 1 - b) cap_n[b] = sd_i;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      armed_q  <= 1'b0;
      lr_q     <= 1'b0;
      pos_q    <= '0;
      cap_q    <= '0;
      shr_q    <= '0;
    end else begin
      primed_q <= primed_n;
      armed_q  <= armed_n;
      lr_q     <= lr_n;
      pos_q    <= pos_n;
      cap_q    <= cap_n;
      shr_q    <= shr_n;
    end
  end

  // A half-frame is reported only once alignment exists (R8)
  assign done_o = frame_edge & armed_q;
  assign left_o = (lr_q == left_level(fmt));
  assign word_o = (fmt == FMT_RJ) ? rj_align(shr_q, rj_len(mode_i[1:0])) : cap_q;

  // R8: the position counter restarts at every frame edge
  a_r8_pos_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_edge |=> (pos_q == {{(POS_W-1){1'b0}}, 1'b1}));

endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              left_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o
);

  logic [DATA_W-1:0] hold_q, hold_n;
  logic              ok_q,   ok_n;
  logic [DATA_W-1:0] lft_q,  lft_n;
  logic [DATA_W-1:0] rgt_q,  rgt_n;
  logic              vld_q,  vld_n;

  always_comb begin
    hold_n = hold_q;
    ok_n   = ok_q;
    lft_n  = lft_q;
    rgt_n  = rgt_q;
    vld_n  = 1'b0;
    if (done_i) begin
      if (left_i) begin
        hold_n = word_i;
        ok_n   = 1'b1;
      end else if (ok_q) begin
        lft_n = hold_q;
        rgt_n = word_i;
        vld_n = 1'b1;
        ok_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      ok_q   <= 1'b0;
      lft_q  <= '0;
      rgt_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      hold_q <= hold_n;
      ok_q   <= ok_n;
      lft_q  <= lft_n;
      rgt_q  <= rgt_n;
      vld_q  <= vld_n;
    end
  end

  assign valid_o = vld_q;
  assign left_o  = lft_q;
  assign right_o = rgt_q;

  // R7/R8: a pair is only reported after a stored left half-frame
  a_r7_left_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> $past(ok_q));

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              lrclk_i,
  input  logic              sdata_i,
  input  logic [2:0]        mode_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o
);

  localparam int PIN_W = 3;

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic [PIN_W-1:0]  pins_s;
  logic              sclk_s, lr_s, sd_s;
  logic              sclk_q;
  logic              bit_rise;
  logic              slot_done, slot_left;
  logic [DATA_W-1:0] slot_word;

  // R9: assert asynchronously, release on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  aud_rx_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    ({sclk_i, lrclk_i, sdata_i}),
    .q_o    (pins_s)
  );
  assign {sclk_s, lr_s, sd_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end
  assign bit_rise = sclk_s & ~sclk_q;

  aud_rx_slot #(.DATA_W(DATA_W)) i_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .bit_en_i (bit_rise),
    .sd_i     (sd_s),
    .lr_i     (lr_s),
    .mode_i   (mode_i),
    .done_o   (slot_done),
    .left_o   (slot_left),
    .word_o   (slot_word)
  );

  aud_rx_pair #(.DATA_W(DATA_W)) i_pair (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .done_i  (slot_done),
    .left_i  (slot_left),
    .word_i  (slot_word),
    .valid_o (valid_o),
    .left_o  (left_o),
    .right_o (right_o)
  );

  // R7: strobe is a single-cycle pulse
  a_r7_valid_single: assert property (@(posedge clk_i) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R7: outputs move only together with the strobe
  a_r7_hold_left: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(left_o) |-> valid_o);
  a_r7_hold_right: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(right_o) |-> valid_o);

  // R1: results follow a sampled rising bit clock edge
  a_r1_after_bit: assert property (@(posedge clk_i) disable iff (!rst_n)
    valid_o |-> $past(bit_rise));

  // R6: the 16-bit right-justified mode leaves the low bits clear
  a_r6_rj16_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    (valid_o && mode_i == MODE_RJ16 && $past(mode_i) == MODE_RJ16)
      |-> (left_o[DATA_W-17:0] == '0 && right_o[DATA_W-17:0] == '0));

endmodule

// File: tb/test_aud_serial_rx.sv
module test_aud_serial_rx;

  localparam int W = 24;
  localparam int K_LJ = 0, K_I2S = 1, K_RJ = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [2:0]   mode = 3'b000;
  logic         valid;
  logic [W-1:0] left, right;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_l[$];
  logic [W-1:0] exp_r[$];
  string        exp_tag[$];

  always #10 clk = ~clk;

  aud_serial_rx i_aud_serial_rx (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .sclk_i  (sclk),
    .lrclk_i (lrclk),
    .sdata_i (sdata),
    .mode_i  (mode),
    .valid_o (valid),
    .left_o  (left),
    .right_o (right)
  );

  task automatic check(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every strobe (R7)
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (exp_l.size() == 0) begin
        check(1'b0, "R8 unexpected pair", left, '0);
      end else begin
        automatic logic [W-1:0] el = exp_l.pop_front();
        automatic logic [W-1:0] er = exp_r.pop_front();
        automatic string        tg = exp_tag.pop_front();
        check(left == el,  {tg, " left"},  left,  el);
        check(right == er, {tg, " right"}, right, er);
      end
    end
  end

  // One bit: data and frame clock change with the falling bit clock (R1)
  task automatic put_bit(input logic lr, input logic d);
    sclk = 1'b0; lrclk = lr; sdata = d;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // One half-frame; bits outside the word are ones
  task automatic send_half(input logic lr, input logic [W-1:0] word, input int kind,
                           input int n, input int bits);
    for (int i = 0; i < bits; i++) begin
      automatic logic d = 1'b1;
      if (kind == K_LJ && i < W)                 d = word[W-1-i];
      else if (kind == K_I2S && i >= 1 && i <= W) d = word[W-i];
      else if (kind == K_RJ && i >= bits - n)     d = word[n-1-(i-(bits-n))];
      put_bit(lr, d);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sclk = 1'b0;
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R9 valid in reset", {{(W-1){1'b0}}, valid}, '0);
    check(left == '0,    "R9 left in reset",  left,  '0);
    check(right == '0,   "R9 right in reset", right, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_batch(input logic [2:0] code, input int kind, input int n,
                           input int bits, input int frames, input string tag);
    logic lvl;
    do_reset();
    mode = code;
    lvl  = (kind != K_I2S);
    // partial lead-in, must never produce output (R8)
    send_half(!lvl, '0, kind, n, 8);
    for (int f = 0; f < frames; f++) begin
      automatic logic [31:0]  rl = $urandom();
      automatic logic [31:0]  rr = $urandom();
      automatic logic [W-1:0] wl = rl[W-1:0];
      automatic logic [W-1:0] wr = rr[W-1:0];
      automatic logic [W-1:0] el, er;
      if (kind == K_RJ) begin
        wl = wl & ((W'(1) << n) - 1'b1);
        wr = wr & ((W'(1) << n) - 1'b1);
        el = wl << (W - n);
        er = wr << (W - n);
      end else if (bits < W) begin
        el = wl & ~((W'(1) << (W - bits)) - 1'b1);
        er = wr & ~((W'(1) << (W - bits)) - 1'b1);
      end else begin
        el = wl;
        er = wr;
      end
      exp_l.push_back(el);
      exp_r.push_back(er);
      exp_tag.push_back(tag);
      send_half(lvl, wl, kind, n, bits);
      send_half(!lvl, wr, kind, n, bits);
    end
    // closing edge completes the final right half-frame
    send_half(lvl, '0, kind, n, 4);
    repeat (20) @(negedge clk);
    check(exp_l.size() == 0, {tag, " R7 missing pairs"}, W'(exp_l.size()), '0);
    exp_l.delete(); exp_r.delete(); exp_tag.delete();
  endtask

  initial begin
    run_batch(3'b000, K_LJ,  24, 32, 3, "R1 R3 left-justified");
    run_batch(3'b001, K_I2S, 24, 32, 3, "R4 I2S");
    run_batch(3'b100, K_RJ,  24, 32, 3, "R5 RJ24");
    run_batch(3'b101, K_RJ,  20, 32, 3, "R5 R6 RJ20");
    run_batch(3'b110, K_RJ,  18, 32, 3, "R5 R6 RJ18");
    run_batch(3'b111, K_RJ,  16, 32, 3, "R5 R6 RJ16");
    run_batch(3'b010, K_LJ,  24, 32, 2, "R2 code 010");
    run_batch(3'b011, K_LJ,  24, 32, 2, "R2 code 011");
    run_batch(3'b000, K_LJ,  24, 16, 3, "R6 short LJ");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule